// File: doc/BRIEF.md
# Tile Register Bulk Load/Store Sequencer

This block moves whole matrix tiles between a word-wide data memory port and two on-chip register files: a tile file of fp32 tiles, each TILE_DIM by TILE_DIM, and a metadata file of 4-bit entries in the same shape. A single command names an operation, a register index and a byte base address. The block then runs the whole sequence of memory beats on its own. A tile load reads one, two or four consecutive tiles into consecutive tile registers, which depends on the register class. A metadata load reads packed nibbles and spreads them across one metadata register. A store writes one tile register back to memory.

The controller is a five-state machine. IDLE accepts a command. Out of IDLE, a valid load goes to LOAD, a valid store goes to STORE, and a command with a bad index or an unknown operation goes to REJECT. LOAD leaves for FINISH when the last read response arrives. STORE leaves for FINISH when the last write is accepted. FINISH and REJECT each last one cycle and return to IDLE. In LOAD the read requests are pipelined: requests keep issuing while earlier responses are still on their way back, so several reads can be outstanding. Responses return in request order. The register files have combinational read ports so a compute unit can consume the tiles.

Top module: `tile_seq_top`

## Requirements
- R1: cmd_ready is high only in IDLE, and a command is taken on a clock edge where cmd_valid and cmd_ready are both high. busy is high from the cycle after acceptance through the cycle in which done is high. While idle, no memory request is raised.
- R2: Operation code 0 (single tile load, register k) issues TILE_DIM*TILE_DIM reads at consecutive word addresses. Word number n goes to row n/TILE_DIM, column n%TILE_DIM of tile register k.
- R3: The base address of every command has its two low bits cleared before use, so every request address is word aligned.
- R4: Operation code 1 (pair load, register k) reads 2*TILE_DIM*TILE_DIM contiguous words. The first tile-sized block fills tile register 2k and the second fills tile register 2k+1.
- R5: Operation code 2 (quad load, register k) reads 4*TILE_DIM*TILE_DIM contiguous words into tile registers 4k, 4k+1, 4k+2 and 4k+3, one tile-sized block each, in ascending order.
- R6: Operation code 3 (metadata load, register k) reads TILE_DIM*TILE_DIM/8 words. Each word yields eight nibbles. The byte at the lowest address is bits 7:0. Within each byte, bits 7:4 come before bits 3:0. Nibble number n lands at row n/TILE_DIM, column n%TILE_DIM of metadata register k, so the high nibble of a byte takes the even column and the low nibble takes the next one.
- R7: Operation code 4 (tile store, register k) issues TILE_DIM*TILE_DIM writes of tile register k in row-major order at consecutive word addresses from the aligned base. Loads never raise mem_req_write.
- R8: If the index is outside its class (tile or store: k < NUM_TREGS; pair: k < NUM_TREGS/2; quad: k < NUM_TREGS/4; metadata: k < NUM_MREGS), or the operation code is 5, 6 or 7, then done and err are both high in the cycle after acceptance. No memory request is made and no register contents change.
- R9: done is a one-cycle pulse in the cycle after the final beat (the last read response, or the last accepted write). err is low for every valid command.
- R10: While mem_req_valid is high and mem_req_ready is low, the request's address, direction and write data stay unchanged on the next cycle. After each accepted request, the next request is at the address 4 bytes higher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Operation code (0 tile, 1 pair, 2 quad, 3 metadata, 4 store) |
| cmd_idx | input | IDX_W | Register index in the class of the operation |
| cmd_addr | input | ADDR_W | Byte base address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Rejected command, high together with done |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | Request is a write |
| mem_req_addr | output | ADDR_W | Word-aligned byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response word |
| tread_reg | input | log2(NUM_TREGS) | Tile read port register |
| tread_row | input | log2(TILE_DIM) | Tile read port row |
| tread_col | input | log2(TILE_DIM) | Tile read port column |
| tread_data | output | 32 | Tile read port element |
| mread_reg | input | log2(NUM_MREGS) | Metadata read port register |
| mread_row | input | log2(TILE_DIM) | Metadata read port row |
| mread_col | input | log2(TILE_DIM) | Metadata read port column |
| mread_data | output | 4 | Metadata read port entry |

## Verification
The properties assume that the memory side sends exactly one in-order read response for each accepted read request, never sends a response while nothing is outstanding, and does not change register contents except through this block. They also assume that a new command is offered only while the block is idle. The stimulus meets these assumptions with a memory model that returns each accepted read after a fixed two-cycle delay. The bench issues commands one at a time and waits for done before the next. Mem_req_ready toggles between always-high and a pattern with gaps, so both back-to-back and stalled requests occur.

// File: rtl/tile_seq_pkg.sv
`timescale 1ns/1ps
package tile_seq_pkg;

    typedef enum logic [2:0] {
        OP_LOAD_ONE  = 3'd0,
        OP_LOAD_PAIR = 3'd1,
        OP_LOAD_QUAD = 3'd2,
        OP_LOAD_META = 3'd3,
        OP_STORE_ONE = 3'd4
    } tile_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOAD   = 3'd1,
        ST_STORE  = 3'd2,
        ST_FINISH = 3'd3,
        ST_REJECT = 3'd4
    } seq_state_e;

    localparam int unsigned NIBS_PER_WORD = 8;

endpackage

// File: rtl/tile_seq_plan.sv
`timescale 1ns/1ps
module tile_seq_plan
    import tile_seq_pkg::*;
#(
    parameter int TILE_DIM  = 16,
    parameter int NUM_TREGS = 4,
    parameter int NUM_MREGS = 2,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 11,
    parameter int TFLAT_W   = 10,
    parameter int MFLAT_W   = 9
) (
    input  logic [2:0]          op,
    input  logic [IDX_W-1:0]    idx,
    input  logic [ADDR_W-1:0]   addr,
    output logic                ok,
    output logic                is_store,
    output logic                is_meta,
    output logic [CNT_W-1:0]    beats,
    output logic [TFLAT_W-1:0]  t_start,
    output logic [MFLAT_W-1:0]  m_start,
    output logic [ADDR_W-1:0]   base
);
    localparam int unsigned TE = TILE_DIM * TILE_DIM;

    int unsigned idx_i;
    int unsigned span;
    int unsigned limit;

    always_comb begin
        idx_i    = 32'(idx);
        span     = 1;
        limit    = 0;
        is_store = 1'b0;
        is_meta  = 1'b0;
        unique case (op)
            OP_LOAD_ONE:  begin span = 1; limit = NUM_TREGS;     end
            OP_LOAD_PAIR: begin span = 2; limit = NUM_TREGS / 2; end
            OP_LOAD_QUAD: begin span = 4; limit = NUM_TREGS / 4; end
            OP_LOAD_META: begin span = 1; limit = NUM_MREGS; is_meta = 1'b1; end
            OP_STORE_ONE: begin span = 1; limit = NUM_TREGS; is_store = 1'b1; end
            default:      begin span = 1; limit = 0;             end
        endcase
        ok      = (idx_i < limit);
        beats   = is_meta ? CNT_W'(TE / NIBS_PER_WORD) : CNT_W'(span * TE);
        t_start = TFLAT_W'(idx_i * span * TE);
        m_start = MFLAT_W'(idx_i * TE);
        base    = addr & ~ADDR_W'(3);
    end

endmodule

// File: rtl/tile_regfile.sv
`timescale 1ns/1ps
module tile_regfile #(
    parameter int NUM_TREGS = 4,
    parameter int TILE_DIM  = 16,
    parameter int TFLAT_W   = 10
) (
    input  logic               clk,
    input  logic               we,
    input  logic [TFLAT_W-1:0] waddr,
    input  logic [31:0]        wdata,
    input  logic [TFLAT_W-1:0] ra_ext,
    output logic [31:0]        rd_ext,
    input  logic [TFLAT_W-1:0] ra_st,
    output logic [31:0]        rd_st
);
    localparam int DEPTH = NUM_TREGS * TILE_DIM * TILE_DIM;

    logic [31:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rd_ext = cells[ra_ext];
    assign rd_st  = cells[ra_st];

endmodule

// File: rtl/meta_regfile.sv
`timescale 1ns/1ps
module meta_regfile
    import tile_seq_pkg::*;
#(
    parameter int NUM_MREGS = 2,
    parameter int TILE_DIM  = 16,
    parameter int MFLAT_W   = 9
) (
    input  logic               clk,
    input  logic               we,
    input  logic [MFLAT_W-1:0] wbase,
    input  logic [31:0]        wword,
    input  logic [MFLAT_W-1:0] ra,
    output logic [3:0]         rd
);
    localparam int DEPTH = NUM_MREGS * TILE_DIM * TILE_DIM;

    logic [3:0] cells [DEPTH];
    logic [3:0] nib [NIBS_PER_WORD];

    // nibble j: byte j/2 of the word, high half first
    for (genvar j = 0; j < NIBS_PER_WORD; j++) begin : g_unpack
        if (j % 2 == 0) begin : g_hi
            assign nib[j] = wword[8*(j/2)+4 +: 4];
        end else begin : g_lo
            assign nib[j] = wword[8*(j/2) +: 4];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            for (int j = 0; j < NIBS_PER_WORD; j++) begin
                cells[MFLAT_W'(32'(wbase) + j)] <= nib[j];
            end
        end
    end

    assign rd = cells[ra];

endmodule

// File: rtl/tile_seq_top.sv
`timescale 1ns/1ps
module tile_seq_top
    import tile_seq_pkg::*;
#(
    parameter int TILE_DIM  = 16,
    parameter int NUM_TREGS = 4,
    parameter int NUM_MREGS = 2,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_valid,
    output logic                              cmd_ready,
    input  logic [2:0]                        cmd_op,
    input  logic [IDX_W-1:0]                  cmd_idx,
    input  logic [ADDR_W-1:0]                 cmd_addr,
    output logic                              busy,
    output logic                              done,
    output logic                              err,
    output logic                              mem_req_valid,
    input  logic                              mem_req_ready,
    output logic                              mem_req_write,
    output logic [ADDR_W-1:0]                 mem_req_addr,
    output logic [31:0]                       mem_req_wdata,
    input  logic                              mem_rsp_valid,
    input  logic [31:0]                       mem_rsp_data,
    input  logic [$clog2(NUM_TREGS)-1:0]      tread_reg,
    input  logic [$clog2(TILE_DIM)-1:0]       tread_row,
    input  logic [$clog2(TILE_DIM)-1:0]       tread_col,
    output logic [31:0]                       tread_data,
    input  logic [$clog2(NUM_MREGS)-1:0]      mread_reg,
    input  logic [$clog2(TILE_DIM)-1:0]       mread_row,
    input  logic [$clog2(TILE_DIM)-1:0]       mread_col,
    output logic [3:0]                        mread_data
);
    localparam int TE      = TILE_DIM * TILE_DIM;
    localparam int CNT_W   = $clog2(4 * TE + 1);
    localparam int TFLAT_W = $clog2(NUM_TREGS * TE);
    localparam int MFLAT_W = $clog2(NUM_MREGS * TE);

    seq_state_e state, state_nx;

    logic [ADDR_W-1:0]  addr_q;
    logic [CNT_W-1:0]   beats_q, issue_cnt, recv_cnt;
    logic [TFLAT_W-1:0] tbase_q;
    logic [MFLAT_W-1:0] mbase_q;
    logic               meta_q;

    logic               p_ok, p_store, p_meta;
    logic [CNT_W-1:0]   p_beats;
    logic [TFLAT_W-1:0] p_tstart;
    logic [MFLAT_W-1:0] p_mstart;
    logic [ADDR_W-1:0]  p_base;

    logic               accept, req_fire, last_issue, last_recv;
    logic               t_we, m_we;
    logic [TFLAT_W-1:0] t_waddr, t_st_addr, t_ext_addr;
    logic [MFLAT_W-1:0] m_wbase, m_ext_addr;

    tile_seq_plan #(
        .TILE_DIM(TILE_DIM), .NUM_TREGS(NUM_TREGS), .NUM_MREGS(NUM_MREGS),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
        .TFLAT_W(TFLAT_W), .MFLAT_W(MFLAT_W)
    ) u_plan (
        .op(cmd_op), .idx(cmd_idx), .addr(cmd_addr),
        .ok(p_ok), .is_store(p_store), .is_meta(p_meta),
        .beats(p_beats), .t_start(p_tstart), .m_start(p_mstart), .base(p_base)
    );

    assign accept     = (state == ST_IDLE) && cmd_valid;
    assign req_fire   = mem_req_valid && mem_req_ready;
    assign last_issue = (issue_cnt == beats_q - CNT_W'(1));
    assign last_recv  = (recv_cnt == beats_q - CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    if (!p_ok)       state_nx = ST_REJECT;
                    else if (p_store) state_nx = ST_STORE;
                    else             state_nx = ST_LOAD;
                end
            end
            ST_LOAD:   if (mem_rsp_valid && last_recv) state_nx = ST_FINISH;
            ST_STORE:  if (mem_req_ready && last_issue) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            ST_REJECT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready     = 1'b0;
        busy          = 1'b1;
        done          = 1'b0;
        err           = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        t_we          = 1'b0;
        m_we          = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                busy      = 1'b0;
            end
            ST_LOAD: begin
                mem_req_valid = (issue_cnt != beats_q);
                t_we          = mem_rsp_valid && !meta_q;
                m_we          = mem_rsp_valid && meta_q;
            end
            ST_STORE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
            end
            ST_FINISH: done = 1'b1;
            ST_REJECT: begin
                done = 1'b1;
                err  = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end

    // command context and beat counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            beats_q   <= '0;
            issue_cnt <= '0;
            recv_cnt  <= '0;
            tbase_q   <= '0;
            mbase_q   <= '0;
            meta_q    <= 1'b0;
        end else if (accept) begin
            addr_q    <= p_base;
            beats_q   <= p_beats;
            issue_cnt <= '0;
            recv_cnt  <= '0;
            tbase_q   <= p_tstart;
            mbase_q   <= p_mstart;
            meta_q    <= p_meta;
        end else begin
            if (req_fire) begin
                issue_cnt <= issue_cnt + CNT_W'(1);
                addr_q    <= addr_q + ADDR_W'(4);
            end
            if (t_we || m_we) recv_cnt <= recv_cnt + CNT_W'(1);
        end
    end

    assign mem_req_addr = addr_q;

    assign t_waddr    = TFLAT_W'(32'(tbase_q) + 32'(recv_cnt));
    assign t_st_addr  = TFLAT_W'(32'(tbase_q) + 32'(issue_cnt));
    assign t_ext_addr = TFLAT_W'(32'(tread_reg) * TE + 32'(tread_row) * TILE_DIM + 32'(tread_col));
    assign m_wbase    = MFLAT_W'(32'(mbase_q) + 32'(recv_cnt) * NIBS_PER_WORD);
    assign m_ext_addr = MFLAT_W'(32'(mread_reg) * TE + 32'(mread_row) * TILE_DIM + 32'(mread_col));

    tile_regfile #(
        .NUM_TREGS(NUM_TREGS), .TILE_DIM(TILE_DIM), .TFLAT_W(TFLAT_W)
    ) u_tiles (
        .clk(clk), .we(t_we), .waddr(t_waddr), .wdata(mem_rsp_data),
        .ra_ext(t_ext_addr), .rd_ext(tread_data),
        .ra_st(t_st_addr), .rd_st(mem_req_wdata)
    );

    meta_regfile #(
        .NUM_MREGS(NUM_MREGS), .TILE_DIM(TILE_DIM), .MFLAT_W(MFLAT_W)
    ) u_meta (
        .clk(clk), .we(m_we), .wbase(m_wbase), .wword(mem_rsp_data),
        .ra(m_ext_addr), .rd(mread_data)
    );

endmodule

// File: rtl/tile_seq_checker.sv
`timescale 1ns/1ps
module tile_seq_checker #(
    parameter int NUM_TREGS = 4,
    parameter int NUM_MREGS = 2,
    parameter int IDX_W     = 4,
    parameter int ADDR_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [2:0]        cmd_op,
    input logic [IDX_W-1:0]  cmd_idx,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [31:0]       mem_req_wdata
);
    int unsigned ix;
    logic        bad_cmd;
    logic        store_q;

    always_comb begin
        ix = 32'(cmd_idx);
        case (cmd_op)
            3'd0, 3'd4: bad_cmd = !(ix < NUM_TREGS);
            3'd1:       bad_cmd = !(ix < NUM_TREGS / 2);
            3'd2:       bad_cmd = !(ix < NUM_TREGS / 4);
            3'd3:       bad_cmd = !(ix < NUM_MREGS);
            default:    bad_cmd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= 1'b0;
        else if (cmd_valid && cmd_ready) store_q <= (cmd_op == 3'd4);
    end

    assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready);
    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> busy);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid);
    assert_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));
    assert_addr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=>
            (!mem_req_valid || mem_req_addr == $past(mem_req_addr) + ADDR_W'(4)));
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && (!mem_req_write || $stable(mem_req_wdata))));
    assert_dir_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_write == store_q));
    assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && bad_cmd) |=> (done && err && !mem_req_valid));
    assert_err_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

bind tile_seq_top tile_seq_checker #(
    .NUM_TREGS(NUM_TREGS), .NUM_MREGS(NUM_MREGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .busy(busy), .done(done), .err(err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata)
);

// File: tb/sim_tile_seq_top.sv
`timescale 1ns/1ps
module sim_tile_seq_top;
    localparam int D  = 4;
    localparam int NT = 8;
    localparam int NM = 2;
    localparam int IW = 4;
    localparam int AW = 32;
    localparam int TE = D * D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [2:0]    cmd_op = '0;
    logic [IW-1:0] cmd_idx = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          busy, done, err;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready;
    logic [AW-1:0] mem_req_addr;
    logic [31:0]   mem_req_wdata;
    logic          mem_rsp_valid;
    logic [31:0]   mem_rsp_data;
    logic [2:0]    tread_reg = '0;
    logic [1:0]    tread_row = '0, tread_col = '0;
    logic [31:0]   tread_data;
    logic [0:0]    mread_reg = '0;
    logic [1:0]    mread_row = '0, mread_col = '0;
    logic [3:0]    mread_data;

    int checks = 0;
    int errors = 0;
    logic throttle = 1'b0;

    always #10 clk = ~clk;

    tile_seq_top #(.TILE_DIM(D), .NUM_TREGS(NT), .NUM_MREGS(NM), .IDX_W(IW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_addr(cmd_addr),
        .busy(busy), .done(done), .err(err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .tread_reg(tread_reg), .tread_row(tread_row), .tread_col(tread_col),
        .tread_data(tread_data),
        .mread_reg(mread_reg), .mread_row(mread_row), .mread_col(mread_col),
        .mread_data(mread_data)
    );

    function automatic logic [31:0] pat(int i);
        return 32'h9E37_2C41 ^ (32'(i) * 32'h0103_0507);
    endfunction

    // memory model: two-cycle read latency, optional ready gaps
    logic [31:0] mem [512];
    logic        p1_v, p2_v;
    logic [31:0] p1_d, p2_d;
    int          cyc, hs_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 512; i++) mem[i] <= pat(i);
            cyc <= 0; hs_cnt <= 0; p1_v <= 1'b0; p2_v <= 1'b0;
            p1_d <= '0; p2_d <= '0; mem_req_ready <= 1'b1;
        end else begin
            cyc <= cyc + 1;
            mem_req_ready <= !throttle || (cyc % 3 != 0);
            p1_v <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                hs_cnt <= hs_cnt + 1;
                if (mem_req_write) mem[mem_req_addr[10:2]] <= mem_req_wdata;
                else begin
                    p1_v <= 1'b1;
                    p1_d <= mem[mem_req_addr[10:2]];
                end
            end
            p2_v <= p1_v;
            p2_d <= p1_d;
        end
    end
    assign mem_rsp_valid = p2_v;
    assign mem_rsp_data  = p2_d;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic run_cmd(input logic [2:0] op, input int idx, input int addr, input bit thr,
                           output bit got_err, output int beats, output int waits);
        int h0;
        @(negedge clk);
        throttle = thr;
        chk(cmd_ready === 1'b1 && busy === 1'b0, "R1 idle before command", {cmd_ready, busy}, 2'b10);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_addr = AW'(addr);
        h0 = hs_cnt;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        waits = 1;
        chk(busy === 1'b1 && cmd_ready === 1'b0, "R1 busy after accept", {busy, cmd_ready}, 2'b10);
        while (done !== 1'b1 && waits < 5000) begin
            @(negedge clk);
            waits++;
            if (done !== 1'b1)
                chk(busy === 1'b1, "R1 busy held", {31'd0, busy}, 1);
        end
        got_err = err;
        beats = hs_cnt - h0;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 done single pulse", {done, busy}, 2'b00);
    endtask

    task automatic get_t(input int t, input int r, input int c, output logic [31:0] d);
        tread_reg = 3'(t); tread_row = 2'(r); tread_col = 2'(c);
        #1 d = tread_data;
    endtask

    task automatic get_m(input int m, input int r, input int c, output logic [3:0] d);
        mread_reg = 1'(m); mread_row = 2'(r); mread_col = 2'(c);
        #1 d = mread_data;
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        summary();
    end

    initial begin
        bit e;
        int n, w;
        logic [31:0] d;
        logic [3:0] nb;
        int vbw [2];
        vbw[0] = 0; vbw[1] = 70;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && err === 1'b0 && cmd_ready === 1'b1 && mem_req_valid === 1'b0,
            "R1 reset state", {busy, done, err, cmd_ready, mem_req_valid}, 5'b00010);

        // R2 / R3: single tile loads with misaligned base, alternate ready gaps (R10)
        for (int t = 0; t < NT; t++) begin
            run_cmd(3'd0, t, t * 64 + 3, t[0], e, n, w);
            chk(!e && n == TE, "R2 single load beats", n, TE);
            for (int k = 0; k < TE; k++) begin
                get_t(t, k / D, k % D, d);
                chk(d === pat(t * 16 + k), "R2 R3 R10 single tile element", d, pat(t * 16 + k));
            end
        end

        // R4: pair loads
        for (int u = 0; u < NT / 2; u++) begin
            run_cmd(3'd1, u, u * 160 + 2, u[0], e, n, w);
            chk(!e && n == 2 * TE, "R4 pair load beats", n, 2 * TE);
            for (int k = 0; k < 2 * TE; k++) begin
                get_t(2 * u + k / TE, (k % TE) / D, k % D, d);
                chk(d === pat(u * 40 + k), "R4 pair tile element", d, pat(u * 40 + k));
            end
        end

        // R5: quad loads
        for (int v = 0; v < NT / 4; v++) begin
            run_cmd(3'd2, v, vbw[v] * 4, !v[0], e, n, w);
            chk(!e && n == 4 * TE, "R5 quad load beats", n, 4 * TE);
            for (int k = 0; k < 4 * TE; k++) begin
                get_t(4 * v + k / TE, (k % TE) / D, k % D, d);
                chk(d === pat(vbw[v] + k), "R5 quad tile element", d, pat(vbw[v] + k));
            end
        end

        // R6: metadata loads, nibble order
        for (int m = 0; m < NM; m++) begin
            run_cmd(3'd3, m, (m * 9 + 5) * 4 + 1, m[0], e, n, w);
            chk(!e && n == TE / 8, "R6 metadata load beats", n, TE / 8);
            for (int k = 0; k < TE; k++) begin
                logic [7:0] by;
                logic [3:0] ex;
                by = 8'(pat(m * 9 + 5 + k / 8) >> (8 * ((k % 8) / 2)));
                ex = (k % 2 == 0) ? by[7:4] : by[3:0];
                get_m(m, k / D, k % D, nb);
                chk(nb === ex, "R6 metadata nibble", 32'(nb), 32'(ex));
            end
        end

        // R7: stores of tiles last filled by the quad loads
        for (int t = 0; t < NT; t++) begin
            run_cmd(3'd4, t, (384 + t * 16) * 4 + 1, t[0], e, n, w);
            chk(!e && n == TE, "R7 store beats", n, TE);
            for (int k = 0; k < TE; k++) begin
                int src;
                src = vbw[t / 4] + (t % 4) * TE + k;
                chk(mem[384 + t * 16 + k] === pat(src), "R7 stored word", mem[384 + t * 16 + k], pat(src));
            end
        end

        // R8: rejected commands
        begin
            logic [2:0] bop [6];
            int bix [6];
            bop[0] = 3'd0; bix[0] = NT;
            bop[1] = 3'd1; bix[1] = NT / 2;
            bop[2] = 3'd2; bix[2] = NT / 4;
            bop[3] = 3'd3; bix[3] = NM;
            bop[4] = 3'd4; bix[4] = NT;
            bop[5] = 3'd5; bix[5] = 0;
            for (int b = 0; b < 6; b++) begin
                run_cmd(bop[b], bix[b], 256, 1'b0, e, n, w);
                chk(e && n == 0 && w == 1, "R8 reject err, no traffic, one cycle",
                    {e, 15'd0, 16'(n)}, {1'b1, 31'd0});
            end
        end
        for (int k = 0; k < TE; k++) begin
            get_t(0, k / D, k % D, d);
            chk(d === pat(k), "R8 tile 0 unchanged", d, pat(k));
        end
        begin
            logic [7:0] by0;
            by0 = pat(5)[7:0];
            get_m(0, 0, 0, nb);
            chk(nb === by0[7:4], "R8 metadata 0 unchanged", 32'(nb), 32'(by0[7:4]));
        end

        summary();
    end

endmodule